// File: doc/BRIEF.md
# I2C Multi-Master Bus Condition Monitor

This block sits beside an I2C master's transaction engine and watches the shared SCL and SDA wires. The wires are asynchronous to the system clock, so both go through a synchronizer chain before any logic looks at them. From the synchronized lines the block detects START and STOP conditions, whichever master made them. It keeps a bus-busy flag so that the engine does not begin a transfer while another master owns the bus.

After the engine's `go` request, the block checks whether the engine's own START has appeared on the wires. It reports that with a one-cycle acknowledge, and the engine waits for it before going on. While the engine sends bits that it controls, the block compares each released (high) SDA bit with the line level. A low reading while SCL is high means another master has won arbitration. The block then raises a sticky lost-arbitration flag, and the engine must release both lines at once. The block drives neither wire.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, bus_busy_o, start_seen_o, stop_seen_o, start_accepted_o and lost_arb_o are all 0.
- R2: A fall of SDA while SCL stays high raises start_seen_o for exactly one cycle. It is seen after the third rising clock edge that follows the line change, because of two synchronizer stages and one output register.
- R3: A rise of SDA while SCL stays high raises stop_seen_o for exactly one cycle, with the same latency as R2.
- R4: Every other change of the line pair gives neither start_seen_o nor stop_seen_o. This covers an SDA change while SCL is low, an SCL-only change, and a change of both lines at once.
- R5: bus_busy_o goes to 1 in the cycle start_seen_o pulses and goes to 0 in the cycle stop_seen_o pulses. A repeated START leaves it at 1.
- R6: START and STOP are detected with sda_drive_low_i at 0, so a condition made by another master counts the same as one made by this master.
- R7: go_i taken while bus_busy_o is 0 arms the monitor. The next START that is seen while sda_drive_low_i is 1 (this master pulling SDA low) pulses start_accepted_o in the same cycle as start_seen_o, and this also disarms the monitor.
- R8: go_i taken while bus_busy_o is 1 does not arm the monitor. A later START of this master gives start_seen_o but no start_accepted_o.
- R9: lost_arb_o is set when tx_active_i is 1, sda_drive_low_i is 0, and the synchronized SCL is 1 while the synchronized SDA is 0. The drive inputs are delayed by the synchronizer depth so that they line up with the line samples.
- R10: No other combination of tx_active_i, sda_drive_low_i, SCL and SDA sets lost_arb_o.
- R11: lost_arb_o stays at 1 until a go_i cycle clears it. It is 0 in the cycle after the go_i edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL wire level |
| sda_i | input | 1 | Raw SDA wire level |
| tx_active_i | input | 1 | The engine is sending bits that it owns (address or write data) |
| sda_drive_low_i | input | 1 | This master is pulling SDA low (0 means released) |
| go_i | input | 1 | One-cycle transaction request from the engine |
| bus_busy_o | output | 1 | A START has been seen and no STOP has followed it |
| start_seen_o | output | 1 | One-cycle pulse for a START from any master |
| stop_seen_o | output | 1 | One-cycle pulse for a STOP from any master |
| start_accepted_o | output | 1 | One-cycle pulse when the armed master's own START appears on the bus |
| lost_arb_o | output | 1 | Sticky flag for arbitration loss, cleared by go_i |

## Verification
A change on the wires or on the drive inputs reaches the outputs after the third rising edge that follows it. go_i acts after the first edge. The bench drives on falling edges and samples on falling edges. At those sample points it checks that nothing has appeared after two edges, that the pulse is present after three, and that it is gone after four. The wide sweeps hold each stimulus for at least four edges and count pulses over a five-cycle window, so no check depends on sampling at exactly one edge.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_t;

  localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];

  initial begin
    assert_depth_min_R2: assert (STAGES >= 2);
  end
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
  import i2c_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_t line_i,
  output logic  start_det_o,
  output logic  start_o,
  output logic  stop_o,
  output logic  busy_o
);
  line_t prev_q;
  logic  stop_det;
  logic  start_q, stop_q, busy_q;

  // both edges judged with SCL high before and after
  assign start_det_o = prev_q.scl & line_i.scl &  prev_q.sda & ~line_i.sda;
  assign stop_det    = prev_q.scl & line_i.scl & ~prev_q.sda &  line_i.sda;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= LINE_IDLE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      prev_q  <= line_i;
      start_q <= start_det_o;
      stop_q  <= stop_det;
      if (start_det_o)   busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign busy_o  = busy_q;

  assert_busy_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> start_q);
  assert_busy_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> stop_q);
endmodule

// File: rtl/i2c_mon_arb.sv
module i2c_mon_arb
  import i2c_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_t line_i,
  input  logic  tx_active_i,
  input  logic  drive_low_i,
  input  logic  go_i,
  input  logic  busy_i,
  input  logic  start_det_i,
  output logic  accepted_o,
  output logic  lost_o
);
  logic armed_q, accepted_q, lost_q;
  logic mismatch, own_start;

  assign mismatch  = tx_active_i & ~drive_low_i & line_i.scl & ~line_i.sda;
  assign own_start = armed_q & start_det_i & drive_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      accepted_q <= 1'b0;
      lost_q     <= 1'b0;
    end else begin
      accepted_q <= own_start;
      if (mismatch)  lost_q <= 1'b1;
      else if (go_i) lost_q <= 1'b0;
      if (own_start || mismatch) armed_q <= 1'b0;
      else if (go_i && !busy_i)  armed_q <= 1'b1;
    end
  end

  assign accepted_o = accepted_q;
  assign lost_o     = lost_q;

  assert_lost_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lost_q) |-> $past(go_i));
  assert_accept_armed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accepted_q) |-> $past(armed_q));
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tx_active_i,
  input  logic sda_drive_low_i,
  input  logic go_i,
  output logic bus_busy_o,
  output logic start_seen_o,
  output logic stop_seen_o,
  output logic start_accepted_o,
  output logic lost_arb_o
);
  logic [1:0] line_raw, line_s, drv_raw, drv_s;
  line_t      line;
  logic       start_det;

  assign line_raw = {scl_i, sda_i};
  assign drv_raw  = {tx_active_i, sda_drive_low_i};

  i2c_mon_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_line_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_raw), .q_o(line_s)
  );

  // drive intent delayed to match the line samples
  i2c_mon_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b00)) u_drv_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(drv_raw), .q_o(drv_s)
  );

  assign line = '{scl: line_s[1], sda: line_s[0]};

  i2c_mon_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line),
    .start_det_o(start_det), .start_o(start_seen_o),
    .stop_o(stop_seen_o), .busy_o(bus_busy_o)
  );

  i2c_mon_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line),
    .tx_active_i(drv_s[1]), .drive_low_i(drv_s[0]),
    .go_i(go_i), .busy_i(bus_busy_o), .start_det_i(start_det),
    .accepted_o(start_accepted_o), .lost_o(lost_arb_o)
  );

  assert_cond_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_seen_o, stop_seen_o}));
  assert_accept_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_accepted_o |-> start_seen_o);
endmodule

// File: tb/sim_i2c_bus_monitor.sv
module sim_i2c_bus_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, tx = 1'b0, drv = 1'b0, go = 1'b0;
  logic busy, st, sp, acc, lost;
  int   n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  i2c_bus_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .tx_active_i(tx), .sda_drive_low_i(drv), .go_i(go),
    .bus_busy_o(busy), .start_seen_o(st), .stop_seen_o(sp),
    .start_accepted_o(acc), .lost_arb_o(lost)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_go();
    go = 1'b1; step(1); go = 1'b0;
  endtask

  initial begin
    #4000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cs, cp;
    bit es, ep;
    step(3);
    chk({busy, st, sp, acc, lost} == 5'b0, "R1", {busy, st, sp, acc, lost}, 0);
    rst_n = 1'b1;
    step(4);

    // R2 exact latency of a foreign START (R6)
    sda = 1'b0; step(2);
    chk(st == 1'b0, "R2 early", st, 0);
    step(1);
    chk(st == 1'b1, "R2 due/R6", st, 1);
    chk(busy == 1'b1, "R5 set", busy, 1);
    step(1);
    chk(st == 1'b0, "R2 width", st, 0);
    // R3 exact latency of STOP
    sda = 1'b1; step(2);
    chk(sp == 1'b0, "R3 early", sp, 0);
    step(1);
    chk(sp == 1'b1 && busy == 1'b0, "R3 due/R5 clear", {sp, busy}, 2);
    step(1);
    chk(sp == 1'b0, "R3 width", sp, 0);

    // R4/R2/R3 sweep of all line pair transitions
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a == b) continue;
        {scl, sda} = a[1:0]; step(6);
        {scl, sda} = b[1:0];
        cs = 0; cp = 0;
        for (int k = 0; k < 5; k++) begin
          step(1);
          cs += int'(st); cp += int'(sp);
        end
        es = a[1] & b[1] & a[0] & ~b[0];
        ep = a[1] & b[1] & ~a[0] & b[0];
        chk(cs == int'(es), "R4 start count", cs, int'(es));
        chk(cp == int'(ep), "R4 stop count", cp, int'(ep));
        if (es) chk(busy == 1'b1, "R5 busy after start", busy, 1);
        if (ep) chk(busy == 1'b0, "R5 busy after stop", busy, 0);
      end
    end
    {scl, sda} = 2'b11; step(6);

    // R5 repeated START keeps busy
    sda = 1'b0; step(4);
    scl = 1'b0; step(2); sda = 1'b1; step(2); scl = 1'b1; step(4);
    sda = 1'b0; step(4);
    chk(busy == 1'b1, "R5 repeated start", busy, 1);
    sda = 1'b1; step(4);
    chk(busy == 1'b0, "R5 stop", busy, 0);

    // R7 own START accepted after go while idle
    pulse_go(); step(2);
    drv = 1'b1; sda = 1'b0; step(2);
    chk(acc == 1'b0, "R7 early", acc, 0);
    step(1);
    chk(acc == 1'b1 && st == 1'b1, "R7 accept", {acc, st}, 3);
    step(1);
    chk(acc == 1'b0, "R7 width", acc, 0);
    drv = 1'b0; sda = 1'b1; step(4);
    // disarmed: a second own START is not accepted
    drv = 1'b1; sda = 1'b0; cs = 0;
    for (int k = 0; k < 5; k++) begin step(1); cs += int'(acc); end
    chk(cs == 0, "R7 disarm", cs, 0);
    drv = 1'b0; sda = 1'b1; step(5);

    // R8 go while busy does not arm
    sda = 1'b0; step(4);
    pulse_go(); step(1);
    sda = 1'b1; step(4);
    drv = 1'b1; sda = 1'b0; cs = 0; cp = 0;
    for (int k = 0; k < 5; k++) begin step(1); cs += int'(acc); cp += int'(st); end
    chk(cs == 0 && cp == 1, "R8 no accept", cs, 0);
    drv = 1'b0; sda = 1'b1; step(5);

    // R9/R10/R11 sweep of tx, drive, scl, sda
    for (int v = 0; v < 16; v++) begin
      bit el;
      pulse_go(); step(1);
      chk(lost == 1'b0, "R11 cleared", lost, 0);
      {tx, drv, scl, sda} = v[3:0];
      el = v[3] & ~v[2] & v[1] & ~v[0];
      step(4);
      chk(lost == el, el ? "R9 set" : "R10 no set", lost, int'(el));
      tx = 1'b0; drv = 1'b0; step(5);
      chk(lost == el, "R11 hold", lost, int'(el));
      {scl, sda} = 2'b11; step(5);
      pulse_go();
      chk(lost == 1'b0, "R11 go clears", lost, 0);
      step(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule